// File: doc/BRIEF.md
# Load Instruction Bus Cycle Sequencer

This block steps a single load instruction of a simple pipelined 32-bit processor through its bus cycles. A start pulse captures the current program counter, the effective address from the ALU, the transfer size, a flag saying whether the destination is the program counter, and a base write-back request. From then on, the block drives the memory address and bus control lines in every cycle, and it raises the register-file enables at the proper points.

A plain load takes three cycles. The first cycle prefetches at pc+8, the second reads the data at the effective address, and the third moves the data into the destination while the bus sits idle. When the loaded register is the program counter, two more cycles follow to refill the pipeline from the loaded value. An abort on the data read cancels the destination write and the refill. In early-abort mode it also cancels the base write-back.

Top module: `load_seq`

## Requirements
- R1: After reset, and while idle, the outputs are mreq_no=1, opc_no=1, seq_o=0, base_we_o=0, dest_we_o=0 and done_o=0.
- R2: The cycle after start_i is sampled high in idle is cycle 1. A load without refill drives addr_o with pc+8, then ea, then pc+12 in cycles 1 to 3, where pc and ea are the values captured at start.
- R3: For a load without refill, mreq_no is 0,1,0, seq_o is 0,0,1 and opc_no is 0,1,1 over cycles 1 to 3.
- R4: A load with dest_pc_i=1 that does not abort runs five cycles. Its addresses are pc+8, ea, pc+12, npc and npc+4, where npc is rdata_i sampled at the end of cycle 2 with bits [1:0] cleared. Over the five cycles, mreq_no is 0,1,0,0,0, seq_o is 0,0,0,1,1 and opc_no is 0,1,1,0,0.
- R5: rw_o is 0 (read) in every cycle. bw_o is the inverse of byte_i (1 = word, 0 = byte) in cycle 2, and 1 in every other cycle.
- R6: base_we_o is high only in cycle 2, and only when wb_req_i was high at start.
- R7: abort_i high in cycle 2 keeps dest_we_o low in cycle 3 and ends a PC-destination load after cycle 3. Without an abort, dest_we_o is high in cycle 3.
- R8: With early_abort_i=1, abort_i high in cycle 2 forces base_we_o low. With early_abort_i=0, an abort leaves base_we_o as R6 gives it.
- R9: done_o is high only in the last cycle of a sequence. start_i is ignored in cycles before the last. start_i high in the last cycle begins a new cycle 1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a load sequence |
| early_abort_i | input | 1 | Early-abort mode: an abort also cancels base write-back |
| pc_i | input | 32 | Current program counter |
| ea_i | input | 32 | Effective address from the ALU |
| byte_i | input | 1 | 1 = byte load, 0 = word load |
| dest_pc_i | input | 1 | Destination register is the program counter |
| wb_req_i | input | 1 | Base register write-back requested |
| abort_i | input | 1 | Data read aborted (sampled in cycle 2) |
| rdata_i | input | 32 | Memory read data |
| addr_o | output | 32 | Memory address |
| mreq_no | output | 1 | Memory request, active low |
| seq_o | output | 1 | Sequential access |
| opc_no | output | 1 | Opcode fetch, active low |
| rw_o | output | 1 | 0 = read, 1 = write |
| bw_o | output | 1 | 1 = word, 0 = byte |
| base_we_o | output | 1 | Base register write-back enable |
| dest_we_o | output | 1 | Destination register write enable |
| done_o | output | 1 | Last cycle of the sequence |

## Verification
The bench sweeps every combination of size, PC destination, write-back request, abort and early-abort mode. It checks each output field in each cycle.

- An aborted PC-destination load is checked to stop at three cycles. A design that went on to refill would drive npc onto the bus.
- The refill address is built from read data whose low bits are set. A design that did not clear them would drive a misaligned fetch address.
- Starts issued during cycle 2 are checked to be ignored. Starts issued in the done cycle are checked to be accepted. Getting either wrong would show as a lost or doubled sequence.
- The seq_o value in cycle 3 is checked in both the refill and the plain case, because it differs between them.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_C1   = 3'd1,
    S_C2   = 3'd2,
    S_C3   = 3'd3,
    S_C4   = 3'd4,
    S_C5   = 3'd5
  } lseq_state_e;
endpackage

// File: rtl/lseq_ctrl.sv
module lseq_ctrl
  import lseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] ea_i,
  input  logic            byte_i,
  input  logic            dest_pc_i,
  input  logic            wb_req_i,
  input  logic            abort_i,
  input  logic [XLEN-1:0] rdata_i,
  output lseq_state_e     state_o,
  output logic [XLEN-1:0] pc_q_o,
  output logic [XLEN-1:0] ea_q_o,
  output logic [XLEN-1:0] npc_q_o,
  output logic            byte_q_o,
  output logic            wb_q_o,
  output logic            aborted_q_o,
  output logic            refill_o
);
  localparam int BYTES = XLEN / 8;
  localparam int ALIGN = $clog2(BYTES);

  lseq_state_e state_q, state_d;
  logic        dest_q;
  logic        accept;

  assign refill_o = dest_q && !aborted_q_o;
  assign accept   = start_i && ((state_q == S_IDLE) ||
                                (state_q == S_C3 && !refill_o) ||
                                (state_q == S_C5));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_C1;
      S_C1:    state_d = S_C2;
      S_C2:    state_d = S_C3;
      S_C3:    state_d = refill_o ? S_C4 : (start_i ? S_C1 : S_IDLE);
      S_C4:    state_d = S_C5;
      S_C5:    state_d = start_i ? S_C1 : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      pc_q_o      <= '0;
      ea_q_o      <= '0;
      npc_q_o     <= '0;
      byte_q_o    <= 1'b0;
      wb_q_o      <= 1'b0;
      dest_q      <= 1'b0;
      aborted_q_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        pc_q_o      <= pc_i;
        ea_q_o      <= ea_i;
        byte_q_o    <= byte_i;
        wb_q_o      <= wb_req_i;
        dest_q      <= dest_pc_i;
        aborted_q_o <= 1'b0;
      end else if (state_q == S_C2) begin
        aborted_q_o <= abort_i;
        npc_q_o     <= {rdata_i[XLEN-1:ALIGN], {ALIGN{1'b0}}};
      end
    end
  end

  assign state_o = state_q;

  // R4: refill only follows the transfer cycle
  a_r4_refill_after_c3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_C4) |-> ($past(state_q) == S_C3));

  // R7: an abort in the data cycle stops the refill
  a_r7_abort_no_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_C2 && abort_i) |=> ##1 (state_q != S_C4));
endmodule

// File: rtl/lseq_bus.sv
module lseq_bus
  import lseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  lseq_state_e     state_i,
  input  logic [XLEN-1:0] pc_q_i,
  input  logic [XLEN-1:0] ea_q_i,
  input  logic [XLEN-1:0] npc_q_i,
  input  logic            byte_q_i,
  input  logic            wb_q_i,
  input  logic            aborted_q_i,
  input  logic            refill_i,
  input  logic            abort_i,
  input  logic            early_abort_i,
  output logic [XLEN-1:0] addr_o,
  output logic            mreq_no,
  output logic            seq_o,
  output logic            opc_no,
  output logic            rw_o,
  output logic            bw_o,
  output logic            base_we_o,
  output logic            dest_we_o,
  output logic            done_o
);
  localparam int BYTES   = XLEN / 8;
  localparam int PF_OFS  = 2 * BYTES;
  localparam int PF_NEXT = 3 * BYTES;

  always_comb begin
    addr_o    = '0;
    mreq_no   = 1'b1;
    seq_o     = 1'b0;
    opc_no    = 1'b1;
    rw_o      = 1'b0;
    bw_o      = 1'b1;
    base_we_o = 1'b0;
    dest_we_o = 1'b0;
    done_o    = 1'b0;
    unique case (state_i)
      S_C1: begin
        addr_o  = pc_q_i + XLEN'(PF_OFS);
        mreq_no = 1'b0;
        opc_no  = 1'b0;
      end
      S_C2: begin
        addr_o    = ea_q_i;
        bw_o      = !byte_q_i;
        base_we_o = wb_q_i && !(early_abort_i && abort_i);
      end
      S_C3: begin
        addr_o    = pc_q_i + XLEN'(PF_NEXT);
        mreq_no   = 1'b0;
        seq_o     = !refill_i;
        dest_we_o = !aborted_q_i;
        done_o    = !refill_i;
      end
      S_C4: begin
        addr_o  = npc_q_i;
        mreq_no = 1'b0;
        seq_o   = 1'b1;
        opc_no  = 1'b0;
      end
      S_C5: begin
        addr_o  = npc_q_i + XLEN'(BYTES);
        mreq_no = 1'b0;
        seq_o   = 1'b1;
        opc_no  = 1'b0;
        done_o  = 1'b1;
      end
      default: ;
    endcase
  end

  // R6: write-back is a single-cycle pulse
  a_r6_wb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_o |=> !base_we_o);

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: destination write only after the data cycle
  a_r7_dest_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_we_o |-> ($past(state_i) == S_C2));
endmodule

// File: rtl/load_seq.sv
module load_seq
  import lseq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            early_abort_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] ea_i,
  input  logic            byte_i,
  input  logic            dest_pc_i,
  input  logic            wb_req_i,
  input  logic            abort_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] addr_o,
  output logic            mreq_no,
  output logic            seq_o,
  output logic            opc_no,
  output logic            rw_o,
  output logic            bw_o,
  output logic            base_we_o,
  output logic            dest_we_o,
  output logic            done_o
);
  lseq_state_e     state;
  logic [XLEN-1:0] pc_q, ea_q, npc_q;
  logic            byte_q, wb_q, aborted_q, refill;

  lseq_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pc_i        (pc_i),
    .ea_i        (ea_i),
    .byte_i      (byte_i),
    .dest_pc_i   (dest_pc_i),
    .wb_req_i    (wb_req_i),
    .abort_i     (abort_i),
    .rdata_i     (rdata_i),
    .state_o     (state),
    .pc_q_o      (pc_q),
    .ea_q_o      (ea_q),
    .npc_q_o     (npc_q),
    .byte_q_o    (byte_q),
    .wb_q_o      (wb_q),
    .aborted_q_o (aborted_q),
    .refill_o    (refill)
  );

  lseq_bus #(.XLEN(XLEN)) u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .state_i       (state),
    .pc_q_i        (pc_q),
    .ea_q_i        (ea_q),
    .npc_q_i       (npc_q),
    .byte_q_i      (byte_q),
    .wb_q_i        (wb_q),
    .aborted_q_i   (aborted_q),
    .refill_i      (refill),
    .abort_i       (abort_i),
    .early_abort_i (early_abort_i),
    .addr_o        (addr_o),
    .mreq_no       (mreq_no),
    .seq_o         (seq_o),
    .opc_no        (opc_no),
    .rw_o          (rw_o),
    .bw_o          (bw_o),
    .base_we_o     (base_we_o),
    .dest_we_o     (dest_we_o),
    .done_o        (done_o)
  );

  // R1: no bus request in the cycle after a sequence ends without restart
  a_r1_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (mreq_no && opc_no && !dest_we_o));

  // R3: the data cycle never requests memory for the following cycle
  a_r3_data_cycle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_o |-> mreq_no);
endmodule

// File: tb/load_seq_tb.sv
`timescale 1ns/1ps
module load_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, early_abort_i = 1'b0;
  logic [31:0] pc_i = '0, ea_i = '0, rdata_i = '0;
  logic        byte_i = 1'b0, dest_pc_i = 1'b0, wb_req_i = 1'b0, abort_i = 1'b0;
  logic [31:0] addr_o;
  logic        mreq_no, seq_o, opc_no, rw_o, bw_o, base_we_o, dest_we_o, done_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  load_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .early_abort_i(early_abort_i),
    .pc_i(pc_i), .ea_i(ea_i), .byte_i(byte_i), .dest_pc_i(dest_pc_i),
    .wb_req_i(wb_req_i), .abort_i(abort_i), .rdata_i(rdata_i),
    .addr_o(addr_o), .mreq_no(mreq_no), .seq_o(seq_o), .opc_no(opc_no),
    .rw_o(rw_o), .bw_o(bw_o), .base_we_o(base_we_o), .dest_we_o(dest_we_o),
    .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " mreq_no"}, 32'(mreq_no), 32'd1);
    chk({tag, " opc_no"}, 32'(opc_no), 32'd1);
    chk({tag, " seq_o"}, 32'(seq_o), 32'd0);
    chk({tag, " base_we"}, 32'(base_we_o), 32'd0);
    chk({tag, " dest_we"}, 32'(dest_we_o), 32'd0);
    chk({tag, " done"}, 32'(done_o), 32'd0);
  endtask

  // pre: start already sampled in the previous sequence's last cycle
  task automatic run(input logic [31:0] pc, input logic [31:0] ea, input logic [31:0] rd,
                     input bit by, input bit dp, input bit wb, input bit ea_mode,
                     input bit ab, input bit pre, input bit ign, input bit chain);
    int n;
    bit refill;
    logic [31:0] npc;
    logic [31:0] e_addr;
    bit e_mreq, e_seq, e_opc, e_bw, e_base, e_dest, e_done;
    refill = dp && !ab;
    n = refill ? 5 : 3;
    npc = {rd[31:2], 2'b00};
    if (!pre) begin
      @(negedge clk_i);
      pc_i = pc; ea_i = ea; byte_i = by; dest_pc_i = dp; wb_req_i = wb;
      early_abort_i = ea_mode; start_i = 1'b1;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 1; c <= n; c++) begin
      if (c > 1) @(negedge clk_i);
      abort_i = (c == 2) ? ab : 1'b0;
      rdata_i = (c == 2) ? rd : 32'h0;
      start_i = (c == 2) && ign;
      #1;
      case (c)
        1: e_addr = pc + 32'd8;
        2: e_addr = ea;
        3: e_addr = pc + 32'd12;
        4: e_addr = npc;
        default: e_addr = npc + 32'd4;
      endcase
      e_mreq = (c == 2);
      e_seq  = (c == 3) ? !refill : (c >= 4);
      e_opc  = (c == 2) || (c == 3);
      e_bw   = (c == 2) ? !by : 1'b1;
      e_base = (c == 2) && wb && !(ea_mode && ab);
      e_dest = (c == 3) && !ab;
      e_done = (c == n);
      chk(refill ? "R4 addr" : "R2 addr", addr_o, e_addr);
      chk(refill ? "R4 mreq_no" : "R3 mreq_no", 32'(mreq_no), 32'(e_mreq));
      chk(refill ? "R4 seq_o" : "R3 seq_o", 32'(seq_o), 32'(e_seq));
      chk(refill ? "R4 opc_no" : "R3 opc_no", 32'(opc_no), 32'(e_opc));
      chk("R5 rw_o", 32'(rw_o), 32'd0);
      chk("R5 bw_o", 32'(bw_o), 32'(e_bw));
      chk((ea_mode && ab) ? "R8 base_we" : "R6 base_we", 32'(base_we_o), 32'(e_base));
      chk("R7 dest_we", 32'(dest_we_o), 32'(e_dest));
      chk("R9 done", 32'(done_o), 32'(e_done));
    end
    abort_i = 1'b0;
    if (chain) start_i = 1'b1;
    else begin
      @(negedge clk_i);
      #1;
      chk_idle(ign ? "R9 ignored start idle" : "R1 idle after");
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1;
    chk_idle("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk_idle("R1 idle");
    for (int k = 0; k < 32; k++) begin
      run(32'h0000_0100 + 32'(k) * 32'h40, 32'h4000_0001 + 32'(k) * 32'h11,
          32'hA000_0003 | (32'(k) << 4),
          k[0], k[1], k[2], k[3], k[4], 1'b0, (k % 3) == 0, 1'b0);
    end
    // R9 back-to-back: start in last cycle of a plain and of a refill load
    run(32'h0000_2000, 32'h0000_3000, 32'h0000_5557, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b1);
    run(32'h0000_2000, 32'h0000_3000, 32'h0000_5557, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
        1'b1, 1'b0, 1'b0);
    run(32'h0000_6000, 32'h0000_7002, 32'h1234_567A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b1);
    run(32'h0000_6000, 32'h0000_7002, 32'h1234_567A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule